// File: doc/BRIEF.md
# Receive FIFO with Character Timeout

This block buffers received characters for a 16550-style serial port. A deserialiser hands it one character per strobe, or a break indication. Host-side strobes read the next byte and read the line status. Two control writes reach it: the FIFO control byte turns buffering on or off, picks the trigger level and clears the queues, and the line control byte sets the frame format. The block holds the data-ready, overrun and break status bits. It also exports the queue occupancy and a trigger-reached flag that an interrupt encoder elsewhere can use.

With buffering on, bytes go into a 16-deep first-in-first-out store. A timer counts bit-time ticks from the last arrival, or from the last read that left data behind. After four character times with data still waiting, it raises a timeout-pending flag. The character time is computed from the frame format. With buffering off, the block acts as a single holding register. `DEPTH` must be at least 14 so that every trigger level can be reached.

Top module: `uart_rx_buffer`

## Requirements
- R1: After reset, buffering is off and the count is 0. Data-ready, overrun, break, timeout-pending, trigger-reached, the transmit-flush pulse and the read data are all 0.
- R2: A FIFO control write stores bit 0 as the buffering enable. When bit 0 is 1, bits 7:6 pick the trigger level: 00 means 1 byte, 01 means 4, 10 means 8, 11 means 14. In buffered mode, `trig_reached` is 1 exactly when the count is at or above that level. In holding mode it follows data-ready.
- R3: A FIFO control write with bit 1 set empties the receive queue. It clears data-ready and break, stops the timer and clears timeout-pending. A write with bit 2 set gives a one-cycle `tx_flush` pulse and leaves the receive queue untouched.
- R4: A FIFO control write that changes the enable bit acts as if bits 1 and 2 were both set. A write that keeps the enable bit and has bits 1 and 2 clear keeps the queue contents.
- R5: In buffered mode, bytes are read back in arrival order. `rbr_data` holds the byte from the clock edge that samples `rbr_rd`.
- R6: In buffered mode, a byte that arrives while 16 bytes are stored is dropped. The stored bytes stay unchanged and overrun is set.
- R7: In holding mode, an arrival while data-ready is 1 sets overrun and replaces the held byte. A read returns the held byte and clears data-ready.
- R8: A break indication stores a zero byte and sets both break and data-ready.
- R9: A buffered read with an empty queue returns 0. A read that leaves the queue empty clears data-ready and break. A read that leaves bytes behind keeps both.
- R10: A line-status read strobe clears break and overrun, and it leaves stored data alone.
- R11: Timeout-pending rises on the tick that completes four character times of ticks. The count starts at the last arrival or at the last read that left data. The flag rises only if the queue is non-empty, and any data read clears it.
- R12: One character time, counted in ticks, is 1 start bit, plus line-control bits 1:0 plus 5 data bits, plus 1 when bit 3 (parity) is set, plus 2 stop bits when bit 2 is set and 1 otherwise.
- R13: `fifo_count` gives the number of stored bytes, from 0 to 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Strobe: a received character is on `rx_data` |
| rx_data | input | DW | Received character |
| rx_break | input | 1 | Strobe: a break condition was received |
| bit_tick | input | 1 | One pulse per bit time |
| fcr_we | input | 1 | FIFO control write strobe |
| fcr_wdata | input | 8 | FIFO control write value |
| lcr_we | input | 1 | Line control write strobe |
| lcr_wdata | input | 8 | Line control write value (bits 3:0 used) |
| rbr_rd | input | 1 | Receive data read strobe |
| lsr_rd | input | 1 | Line status read strobe |
| rbr_data | output | DW | Byte returned by the last read |
| data_ready | output | 1 | Data is waiting to be read |
| overrun | output | 1 | A character was lost |
| break_seen | output | 1 | A break was received |
| timeout_pend | output | 1 | Data has sat unread for four character times |
| fifo_count | output | $clog2(DEPTH+1) | Stored byte count |
| trig_reached | output | 1 | Occupancy at or above the trigger level |
| fifo_on | output | 1 | Buffering enabled |
| tx_flush | output | 1 | One-cycle request to clear the transmit queue |

## Verification
If the read or write pointers drift, the next read returns a byte out of order, or a stale byte, on the cycle right after the strobe. The full-queue drain check catches this within sixteen reads. An occupancy count that is off by one shows up on `fifo_count` straight away. It also shows as `trig_reached` flipping one byte early or late, or as data-ready dropping while bytes remain. A wrong frame length or timer limit moves the rise of `timeout_pend` by whole ticks, so the bench counts ticks exactly to one below and then exactly to the limit, for three frame formats.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

  localparam int unsigned FRAME_MAX = 12;

  typedef enum logic [1:0] {
    LVL_1  = 2'b00,
    LVL_4  = 2'b01,
    LVL_8  = 2'b10,
    LVL_14 = 2'b11
  } trig_sel_e;

  // R2: trigger level in bytes
  function automatic logic [4:0] trig_level(input trig_sel_e sel);
    case (sel)
      LVL_1:   return 5'd1;
      LVL_4:   return 5'd4;
      LVL_8:   return 5'd8;
      default: return 5'd14;
    endcase
  endfunction

  // R12: bits per character from line-control bits 3:0
  function automatic logic [3:0] frame_bits(input logic [3:0] fmt);
    logic [3:0] n;
    n = 4'd6 + {2'b00, fmt[1:0]};
    n = n + {3'b000, fmt[3]};
    n = n + (fmt[2] ? 4'd2 : 4'd1);
    return n;
  endfunction

endpackage

// File: rtl/rxb_storage.sv
module rxb_storage #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_q
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= mem[rd_addr];
  end

endmodule

// File: rtl/rxb_occupancy.sv
module rxb_occupancy #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic          clear,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] count,
  output logic [CW-1:0] count_nxt
);

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    if (clear) count_nxt = '0;
    else       count_nxt = count + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      count <= count_nxt;
    end
  end

  // R13
  count_le_depth_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  // R6
  no_push_full_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> count != CW'(DEPTH));

  // R9
  no_pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> count != '0);

endmodule

// File: rtl/rxb_char_timer.sv
module rxb_char_timer
  import rxb_pkg::*;
#(
  parameter int unsigned TO_MULT   = 4,
  localparam int unsigned LIMIT_MAX = TO_MULT * FRAME_MAX,
  localparam int unsigned TW        = $clog2(LIMIT_MAX + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] fmt,
  input  logic       bit_tick,
  input  logic       restart,
  input  logic       cancel,
  output logic       expired
);

  logic          active_q;
  logic [TW-1:0] cnt_q;
  logic [TW-1:0] limit;

  assign limit   = TW'(TO_MULT * frame_bits(fmt));
  assign expired = active_q && bit_tick && !restart && !cancel &&
                   (cnt_q >= limit - TW'(1));

  always_ff @(posedge clk) begin
    if (rst || cancel) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (restart) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (expired) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (active_q && bit_tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R11
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    active_q |-> cnt_q < TW'(LIMIT_MAX));

  // R3
  cancel_stops_chk: assert property (@(posedge clk) disable iff (rst)
    cancel |=> !active_q);

endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
  import rxb_pkg::*;
#(
  parameter int unsigned DW      = 8,
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned TO_MULT = 4,
  localparam int unsigned AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW     = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_break,
  input  logic          bit_tick,
  input  logic          fcr_we,
  input  logic [7:0]    fcr_wdata,
  input  logic          lcr_we,
  input  logic [7:0]    lcr_wdata,
  input  logic          rbr_rd,
  input  logic          lsr_rd,
  output logic [DW-1:0] rbr_data,
  output logic          data_ready,
  output logic          overrun,
  output logic          break_seen,
  output logic          timeout_pend,
  output logic [CW-1:0] fifo_count,
  output logic          trig_reached,
  output logic          fifo_on,
  output logic          tx_flush
);

  logic          fifo_en_q;
  trig_sel_e     lvl_q;
  logic [3:0]    fmt_q;
  logic [DW-1:0] hold_q, alt_q, ram_q;
  logic          src_ram_q;
  logic          dr_q, ovr_q, brk_q, pend_q, trig_q, txf_q;

  logic          push_req, en_change, clr_rx, clr_tx;
  logic          full, empty, do_push, do_pop, rd_live, ovr_set;
  logic          restart, expired, en_nxt, dr_nxt, brk_nxt, trig_nxt;
  logic          rd_clears;
  trig_sel_e     lvl_nxt;
  logic [DW-1:0] push_byte;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count_q, count_nxt;
  logic          unused_bits;

  assign unused_bits = ^{fcr_wdata[5:3], lcr_wdata[7:4]};

  always_comb begin
    push_req  = rx_valid | rx_break;
    push_byte = rx_break ? '0 : rx_data;
    en_change = fcr_we && (fcr_wdata[0] != fifo_en_q);
    clr_rx    = fcr_we && (fcr_wdata[1] || en_change);
    clr_tx    = fcr_we && (fcr_wdata[2] || en_change);
    full      = (count_q == CW'(DEPTH));
    empty     = (count_q == '0);
    do_push   = fifo_en_q && push_req && !clr_rx && !full;
    do_pop    = fifo_en_q && rbr_rd && !clr_rx && !empty;
    rd_live   = rbr_rd && !clr_rx;
    ovr_set   = push_req && !clr_rx && (fifo_en_q ? full : dr_q);
    restart   = fifo_en_q && !clr_rx &&
                (push_req || (rd_live && count_nxt != '0));
    en_nxt    = fcr_we ? fcr_wdata[0] : fifo_en_q;
    lvl_nxt   = (fcr_we && fcr_wdata[0]) ? trig_sel_e'(fcr_wdata[7:6]) : lvl_q;
    rd_clears = rd_live && (!fifo_en_q || count_nxt == '0);

    if (clr_rx)          dr_nxt = 1'b0;
    else if (push_req)   dr_nxt = 1'b1;
    else if (rd_clears)  dr_nxt = 1'b0;
    else                 dr_nxt = dr_q;

    if (clr_rx)                   brk_nxt = 1'b0;
    else if (rx_break)            brk_nxt = 1'b1;
    else if (lsr_rd || rd_clears) brk_nxt = 1'b0;
    else                          brk_nxt = brk_q;

    trig_nxt = en_nxt ? (count_nxt >= CW'(trig_level(lvl_nxt))) : dr_nxt;
  end

  rxb_occupancy #(.DEPTH(DEPTH)) u_occ (
    .clk       (clk),
    .rst       (rst),
    .push      (do_push),
    .pop       (do_pop),
    .clear     (clr_rx),
    .wr_ptr    (wr_ptr),
    .rd_ptr    (rd_ptr),
    .count     (count_q),
    .count_nxt (count_nxt)
  );

  rxb_storage #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (do_push),
    .wr_addr (wr_ptr),
    .wr_data (push_byte),
    .rd_en   (do_pop),
    .rd_addr (rd_ptr),
    .rd_q    (ram_q)
  );

  rxb_char_timer #(.TO_MULT(TO_MULT)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .fmt      (fmt_q),
    .bit_tick (bit_tick),
    .restart  (restart),
    .cancel   (clr_rx),
    .expired  (expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_en_q <= 1'b0;
      lvl_q     <= LVL_1;
      fmt_q     <= '0;
      hold_q    <= '0;
      alt_q     <= '0;
      src_ram_q <= 1'b0;
      dr_q      <= 1'b0;
      ovr_q     <= 1'b0;
      brk_q     <= 1'b0;
      pend_q    <= 1'b0;
      trig_q    <= 1'b0;
      txf_q     <= 1'b0;
    end else begin
      fifo_en_q <= en_nxt;
      lvl_q     <= lvl_nxt;
      if (lcr_we) fmt_q <= lcr_wdata[3:0];
      if (!fifo_en_q && push_req && !clr_rx) hold_q <= push_byte;
      if (rd_live) begin
        src_ram_q <= fifo_en_q && !empty;
        alt_q     <= fifo_en_q ? '0 : hold_q;
      end
      dr_q  <= dr_nxt;
      brk_q <= brk_nxt;
      if (ovr_set)     ovr_q <= 1'b1;
      else if (lsr_rd) ovr_q <= 1'b0;
      if (clr_rx || rd_live)     pend_q <= 1'b0;
      else if (expired && !empty) pend_q <= 1'b1;
      trig_q <= trig_nxt;
      txf_q  <= clr_tx;
    end
  end

  assign rbr_data     = src_ram_q ? ram_q : alt_q;
  assign data_ready   = dr_q;
  assign overrun      = ovr_q;
  assign break_seen   = brk_q;
  assign timeout_pend = pend_q;
  assign fifo_count   = count_q;
  assign trig_reached = trig_q;
  assign fifo_on      = fifo_en_q;
  assign tx_flush     = txf_q;

  // R6
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_en_q && full && push_req && !rbr_rd && !fcr_we)
      |=> (fifo_count == CW'(DEPTH)) && overrun);

  // R10
  lsr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (lsr_rd && !rx_valid && !rx_break) |=> (!overrun && !break_seen));

  // R9
  drain_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_en_q && rbr_rd && count_q == CW'(1) && !push_req && !fcr_we)
      |=> (!data_ready && !break_seen && fifo_count == '0));

  // R3
  rx_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (fcr_we && fcr_wdata[1]) |=> (fifo_count == '0 && !timeout_pend && !data_ready));

  // R8
  break_mark_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_break && !fcr_we) |=> (break_seen && data_ready));

endmodule

// File: tb/uart_rx_buffer_tb.sv
module uart_rx_buffer_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_valid = 1'b0, rx_break = 1'b0, bit_tick = 1'b0;
  logic [7:0] rx_data = '0;
  logic       fcr_we = 1'b0, lcr_we = 1'b0, rbr_rd = 1'b0, lsr_rd = 1'b0;
  logic [7:0] fcr_wdata = '0, lcr_wdata = '0;
  logic [7:0] rbr_data;
  logic       data_ready, overrun, break_seen, timeout_pend;
  logic [4:0] fifo_count;
  logic       trig_reached, fifo_on, tx_flush;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  uart_rx_buffer u_dut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_break(rx_break), .bit_tick(bit_tick), .fcr_we(fcr_we),
    .fcr_wdata(fcr_wdata), .lcr_we(lcr_we), .lcr_wdata(lcr_wdata),
    .rbr_rd(rbr_rd), .lsr_rd(lsr_rd), .rbr_data(rbr_data),
    .data_ready(data_ready), .overrun(overrun), .break_seen(break_seen),
    .timeout_pend(timeout_pend), .fifo_count(fifo_count),
    .trig_reached(trig_reached), .fifo_on(fifo_on), .tx_flush(tx_flush)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic push(input logic [7:0] b);
    rx_valid = 1'b1; rx_data = b; cyc(); rx_valid = 1'b0;
  endtask

  task automatic send_break();
    rx_break = 1'b1; cyc(); rx_break = 1'b0;
  endtask

  task automatic rd(output logic [7:0] v);
    rbr_rd = 1'b1; cyc(); rbr_rd = 1'b0; v = rbr_data;
  endtask

  task automatic wr_fcr(input logic [7:0] v);
    fcr_we = 1'b1; fcr_wdata = v; cyc(); fcr_we = 1'b0;
  endtask

  task automatic wr_lcr(input logic [7:0] v);
    lcr_we = 1'b1; lcr_wdata = v; cyc(); lcr_we = 1'b0;
  endtask

  task automatic rd_lsr();
    lsr_rd = 1'b1; cyc(); lsr_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    bit_tick = 1'b1; repeat (n) cyc(); bit_tick = 1'b0;
  endtask

  function automatic int frame_len(input logic [7:0] f);
    return 1 + (int'(f[1:0]) + 5) + int'(f[3]) + (f[2] ? 2 : 1);
  endfunction

  task automatic t_reset();
    chk("R1 count", fifo_count, 0);
    chk("R1 data_ready", data_ready, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 break", break_seen, 0);
    chk("R1 timeout", timeout_pend, 0);
    chk("R1 trig", trig_reached, 0);
    chk("R1 fifo_on", fifo_on, 0);
    chk("R1 tx_flush", tx_flush, 0);
    chk("R1 rbr_data", rbr_data, 0);
  endtask

  task automatic t_holding();
    logic [7:0] v;
    push(8'hA5);
    chk("R7 dr after first", data_ready, 1);
    chk("R7 no overrun yet", overrun, 0);
    chk("R2 trig follows dr", trig_reached, 1);
    push(8'h3C);
    chk("R7 overrun on second", overrun, 1);
    rd(v);
    chk("R7 replaced byte", v, 8'h3C);
    chk("R7 dr cleared", data_ready, 0);
    chk("R13 count stays 0 in holding mode", fifo_count, 0);
    rd_lsr();
    chk("R10 overrun cleared", overrun, 0);
    send_break();
    chk("R8 holding break flag", break_seen, 1);
    rd(v);
    chk("R8 holding break byte", v, 0);
    chk("R9 holding break cleared by read", break_seen, 0);
  endtask

  task automatic t_order();
    logic [7:0] v;
    wr_fcr(8'h41);
    chk("R2 fifo_on", fifo_on, 1);
    chk("R4 enable change flushes tx", tx_flush, 1);
    cyc();
    chk("R3 tx_flush one cycle", tx_flush, 0);
    push(8'h01); push(8'h02); push(8'h03);
    chk("R13 count 3", fifo_count, 3);
    chk("R2 below level 4", trig_reached, 0);
    push(8'h04);
    chk("R2 at level 4", trig_reached, 1);
    for (int i = 1; i <= 4; i++) begin
      rd(v);
      chk("R5 order", v, i);
      chk("R9 dr while bytes remain", data_ready, (i < 4) ? 1 : 0);
    end
    rd(v);
    chk("R9 empty read returns 0", v, 0);
  endtask

  task automatic t_levels();
    int lv[4] = '{1, 4, 8, 14};
    for (int s = 0; s < 4; s++) begin
      wr_fcr(8'(s << 6) | 8'h03);
      for (int k = 0; k < lv[s] - 1; k++) push(8'(k));
      chk($sformatf("R2 level %0d not reached", lv[s]), trig_reached, 0);
      push(8'hFF);
      chk($sformatf("R2 level %0d reached", lv[s]), trig_reached, 1);
    end
    wr_fcr(8'h03);
    chk("R3 cleared after levels", fifo_count, 0);
  endtask

  task automatic t_full();
    logic [7:0] v;
    for (int i = 0; i < 16; i++) push(8'(8'h10 + i));
    chk("R13 full count", fifo_count, 16);
    chk("R6 no overrun at full", overrun, 0);
    push(8'hEE);
    chk("R6 overrun on extra", overrun, 1);
    chk("R6 count kept", fifo_count, 16);
    for (int i = 0; i < 16; i++) begin
      rd(v);
      chk("R6 contents intact", v, 8'h10 + i);
    end
    chk("R9 dr cleared at empty", data_ready, 0);
    rd_lsr();
    chk("R10 overrun cleared", overrun, 0);
  endtask

  task automatic t_break();
    logic [7:0] v;
    push(8'h55);
    send_break();
    chk("R8 break stored", fifo_count, 2);
    chk("R8 break flag", break_seen, 1);
    rd(v);
    chk("R5 data before break", v, 8'h55);
    chk("R9 break kept while data remains", break_seen, 1);
    rd(v);
    chk("R8 break byte zero", v, 0);
    chk("R9 break cleared at empty", break_seen, 0);
    chk("R9 dr cleared at empty", data_ready, 0);
    send_break();
    rd_lsr();
    chk("R10 lsr read clears break", break_seen, 0);
    chk("R10 data kept", data_ready, 1);
    rd(v);
  endtask

  task automatic t_clear();
    push(8'h21); push(8'h22);
    wr_fcr(8'h01);
    chk("R4 same enable keeps data", fifo_count, 2);
    chk("R4 no tx flush", tx_flush, 0);
    wr_fcr(8'h05);
    chk("R3 tx clear keeps rx", fifo_count, 2);
    chk("R3 tx clear pulse", tx_flush, 1);
    wr_fcr(8'h03);
    chk("R3 rx clear count", fifo_count, 0);
    chk("R3 rx clear dr", data_ready, 0);
    push(8'h31); push(8'h32);
    wr_fcr(8'h00);
    chk("R4 disable flushes rx", fifo_count, 0);
    chk("R4 disable flushes tx", tx_flush, 1);
    chk("R4 fifo off", fifo_on, 0);
    wr_fcr(8'h01);
    chk("R4 re-enable", fifo_on, 1);
  endtask

  task automatic t_timeout(input logic [7:0] fmt);
    logic [7:0] v;
    int lim;
    lim = 4 * frame_len(fmt);
    wr_lcr(fmt);
    push(8'h77);
    ticks(lim - 1);
    chk($sformatf("R12 fmt %0h no timeout at %0d", fmt, lim - 1), timeout_pend, 0);
    ticks(1);
    chk($sformatf("R11 fmt %0h timeout at %0d", fmt, lim), timeout_pend, 1);
    rd(v);
    chk("R11 read clears pending", timeout_pend, 0);
  endtask

  task automatic t_timeout_misc();
    logic [7:0] v;
    wr_lcr(8'h03);
    push(8'h41); push(8'h42);
    ticks(20);
    rd(v);
    ticks(39);
    chk("R11 read leaving data restarts", timeout_pend, 0);
    ticks(1);
    chk("R11 timeout after restart by read", timeout_pend, 1);
    rd(v);
    chk("R11 pending cleared", timeout_pend, 0);
    push(8'h43);
    rd(v);
    ticks(45);
    chk("R11 no timeout when empty", timeout_pend, 0);
    push(8'h44);
    ticks(30);
    wr_fcr(8'h03);
    ticks(20);
    chk("R3 clear cancels timeout", timeout_pend, 0);
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst = 1'b0;
    cyc();
    t_reset();
    t_holding();
    t_order();
    t_levels();
    t_full();
    t_break();
    t_clear();
    t_timeout(8'h03);
    t_timeout(8'h0F);
    t_timeout(8'h00);
    t_timeout_misc();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule